// File: doc/BRIEF.md
# Trap Return State Unit

This unit carries out the two trap-return operations of a processor core that may include hypervisor support: the supervisor-level return and the machine-level return. On a request it takes the current privilege level, the virtualization flag, the interrupt-enable stack bits, the saved-privilege fields, the two trap-return trap controls, the saved return addresses and the extension straps. It then decides whether the return is legal. For a legal return it produces the popped status bits, the new privilege, the new virtualization flag and the return address. For an illegal one it reports an exception with a cause code.

The verdict is registered: it appears one clock after the request strobe, together with a one-cycle response valid. A legal return raises a commit flag that the status-register file and the fetch unit use to take the new values. An illegal return raises an exception flag instead. In that case the state outputs repeat the inputs unchanged and the return address reads zero. Legality checks are evaluated in a fixed order, and the first one that fails sets the cause.

Top module: `trap_ret_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_commit and rsp_exc are 0 and nxt_priv is machine (3). Privilege encoding: user=0, supervisor=1, machine=3.
- R2: Every cycle with req_valid high produces rsp_valid high exactly one clock later, and a cycle without a request gives rsp_valid low one clock later. While rsp_valid is high, exactly one of rsp_commit and rsp_exc is high.
- R3: A supervisor return (req_is_mret=0) issued at user privilege raises rsp_exc with cause 2 (illegal instruction).
- R4: When has_c is 0 and bits [1:0] of the selected return address are nonzero, the return raises cause 0 (misaligned target). With has_c at 1 the same address commits.
- R5: A supervisor return with st_tsr set raises cause 2 when issued at supervisor privilege. At machine privilege it commits.
- R6: A supervisor return with has_h=1, cur_virt=1 and hs_vtsr=1 raises cause 22 (virtual instruction).
- R7: A committed supervisor return gives nxt_sie = old st_spie, nxt_spie = 1 and nxt_spp = 0, sets nxt_priv to supervisor if the old st_spp was 1 and to user otherwise, and sets ret_pc to sepc.
- R8: A committed supervisor return with has_h=1 and cur_virt=0 clears nxt_spv and sets nxt_virt to the old hs_spv. In any other case nxt_virt and nxt_spv equal their inputs.
- R9: A machine return (req_is_mret=1) issued below machine privilege raises cause 2.
- R10: A committed machine return gives nxt_mie = old st_mpie, nxt_mpie = 1, nxt_mpp = 0 and nxt_mpv = 0, sets nxt_priv to the old st_mpp, and sets ret_pc to mepc.
- R11: A committed machine return sets nxt_virt to the old st_mpv when has_h=1 and leaves it equal to cur_virt when has_h=0.
- R12: A machine return with has_pmp=1, pmp_rules=0 and st_mpp not machine raises cause 2. It commits when st_mpp is machine or when pmp_rules is nonzero.
- R13: Checks are ordered. For a supervisor return the order is privilege, alignment, st_tsr, then hs_vtsr. For a machine return the order is privilege, alignment, then the protection-rule check. The first failing check sets the cause.
- R14: On an exception, rsp_commit is 0, every nxt_* output equals its input and ret_pc is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Return request strobe |
| req_is_mret | input | 1 | 1 = machine return, 0 = supervisor return |
| cur_priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| cur_virt | input | 1 | Current virtualization flag |
| st_sie | input | 1 | Supervisor interrupt enable |
| st_spie | input | 1 | Supervisor previous interrupt enable |
| st_spp | input | 1 | Supervisor previous privilege |
| st_mie | input | 1 | Machine interrupt enable |
| st_mpie | input | 1 | Machine previous interrupt enable |
| st_mpp | input | 2 | Machine previous privilege |
| st_mpv | input | 1 | Machine previous virtualization |
| st_tsr | input | 1 | Trap supervisor return outside machine mode |
| hs_spv | input | 1 | Hypervisor saved previous virtualization |
| hs_vtsr | input | 1 | Trap supervisor return while virtualized |
| sepc | input | XLEN | Supervisor return address |
| mepc | input | XLEN | Machine return address |
| has_c | input | 1 | Compressed instructions present |
| has_h | input | 1 | Hypervisor support present |
| has_pmp | input | 1 | Memory protection rules supported |
| pmp_rules | input | RULE_W | Number of configured protection rules |
| rsp_valid | output | 1 | Verdict valid, one cycle after request |
| rsp_commit | output | 1 | Return legal, take new state |
| rsp_exc | output | 1 | Return illegal, exception raised |
| rsp_cause | output | 5 | Exception cause (0, 2 or 22) |
| nxt_priv | output | 2 | New privilege |
| nxt_virt | output | 1 | New virtualization flag |
| nxt_sie | output | 1 | New supervisor interrupt enable |
| nxt_spie | output | 1 | New supervisor previous enable |
| nxt_spp | output | 1 | New supervisor previous privilege |
| nxt_mie | output | 1 | New machine interrupt enable |
| nxt_mpie | output | 1 | New machine previous enable |
| nxt_mpp | output | 2 | New machine previous privilege |
| nxt_mpv | output | 1 | New machine previous virtualization |
| nxt_spv | output | 1 | New hypervisor saved virtualization |
| ret_pc | output | XLEN | Return target (0 on exception) |

## Verification
The hardest situations to reach are those where several legality checks fail at once, because only the first one in the fixed order may set the cause. The bench therefore drives requests that combine a low privilege with a misaligned target, a misaligned target with the trap-return control set, and both trap-return controls together, and it expects the earlier cause each time. The hypervisor virtualization restore is also covered on both sides: with virtualization off, where the saved flag is popped, and with it on, where the flag must hold.

// File: rtl/trs_pkg.sv
package trs_pkg;

    localparam logic [1:0] PRIV_U = 2'd0;
    localparam logic [1:0] PRIV_S = 2'd1;
    localparam logic [1:0] PRIV_M = 2'd3;

    localparam int CAUSE_W = 5;
    localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 5'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_VIRT     = 5'd22;

    typedef struct packed {
        logic [1:0] priv;
        logic       virt;
        logic       sie;
        logic       spie;
        logic       spp;
        logic       mie;
        logic       mpie;
        logic [1:0] mpp;
        logic       mpv;
        logic       spv;
    } trs_state_t;

    typedef struct packed {
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        trs_state_t         st;
    } trs_verdict_t;

endpackage

// File: rtl/trs_sret_eval.sv
module trs_sret_eval
    import trs_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  trs_state_t    cur,
    input  logic          tsr,
    input  logic          vtsr,
    input  logic          has_c,
    input  logic          has_h,
    input  logic [XLEN-1:0] epc,
    output trs_verdict_t  verdict
);

    logic misaligned;
    assign misaligned = !has_c && (epc[1:0] != 2'b00);

    always_comb begin
        verdict       = '0;
        verdict.st    = cur;
        if (cur.priv < PRIV_S) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else if (misaligned) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_MISALIGN;
        end else if (tsr && (cur.priv != PRIV_M)) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else if (has_h && cur.virt && vtsr) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_VIRT;
        end else begin
            verdict.st.sie  = cur.spie;
            verdict.st.spie = 1'b1;
            verdict.st.spp  = 1'b0;
            verdict.st.priv = cur.spp ? PRIV_S : PRIV_U;
            if (has_h && !cur.virt) begin
                verdict.st.spv  = 1'b0;
                verdict.st.virt = cur.spv;
            end
        end
    end

endmodule

// File: rtl/trs_mret_eval.sv
module trs_mret_eval
    import trs_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RULE_W = 5
) (
    input  trs_state_t      cur,
    input  logic            has_c,
    input  logic            has_h,
    input  logic            has_pmp,
    input  logic [RULE_W-1:0] pmp_rules,
    input  logic [XLEN-1:0] epc,
    output trs_verdict_t    verdict
);

    logic misaligned;
    logic no_rules_block;
    assign misaligned     = !has_c && (epc[1:0] != 2'b00);
    assign no_rules_block = has_pmp && (pmp_rules == '0) && (cur.mpp != PRIV_M);

    always_comb begin
        verdict    = '0;
        verdict.st = cur;
        if (cur.priv != PRIV_M) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else if (misaligned) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_MISALIGN;
        end else if (no_rules_block) begin
            verdict.exc   = 1'b1;
            verdict.cause = CAUSE_ILLEGAL;
        end else begin
            verdict.st.mie  = cur.mpie;
            verdict.st.mpie = 1'b1;
            verdict.st.mpp  = PRIV_U;
            verdict.st.mpv  = 1'b0;
            verdict.st.priv = cur.mpp;
            if (has_h) begin
                verdict.st.virt = cur.mpv;
            end
        end
    end

endmodule

// File: rtl/trap_ret_unit.sv
module trap_ret_unit
    import trs_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RULE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_is_mret,
    input  logic [1:0]        cur_priv,
    input  logic              cur_virt,
    input  logic              st_sie,
    input  logic              st_spie,
    input  logic              st_spp,
    input  logic              st_mie,
    input  logic              st_mpie,
    input  logic [1:0]        st_mpp,
    input  logic              st_mpv,
    input  logic              st_tsr,
    input  logic              hs_spv,
    input  logic              hs_vtsr,
    input  logic [XLEN-1:0]   sepc,
    input  logic [XLEN-1:0]   mepc,
    input  logic              has_c,
    input  logic              has_h,
    input  logic              has_pmp,
    input  logic [RULE_W-1:0] pmp_rules,
    output logic              rsp_valid,
    output logic              rsp_commit,
    output logic              rsp_exc,
    output logic [4:0]        rsp_cause,
    output logic [1:0]        nxt_priv,
    output logic              nxt_virt,
    output logic              nxt_sie,
    output logic              nxt_spie,
    output logic              nxt_spp,
    output logic              nxt_mie,
    output logic              nxt_mpie,
    output logic [1:0]        nxt_mpp,
    output logic              nxt_mpv,
    output logic              nxt_spv,
    output logic [XLEN-1:0]   ret_pc
);

    typedef struct packed {
        logic               valid;
        logic               commit;
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        trs_state_t         st;
        logic [XLEN-1:0]    pc;
    } resp_t;

    trs_state_t   cur_st;
    trs_verdict_t s_verdict;
    trs_verdict_t m_verdict;
    trs_verdict_t pick;
    resp_t        resp_d;
    resp_t        resp_q;

    always_comb begin
        cur_st      = '0;
        cur_st.priv = cur_priv;
        cur_st.virt = cur_virt;
        cur_st.sie  = st_sie;
        cur_st.spie = st_spie;
        cur_st.spp  = st_spp;
        cur_st.mie  = st_mie;
        cur_st.mpie = st_mpie;
        cur_st.mpp  = st_mpp;
        cur_st.mpv  = st_mpv;
        cur_st.spv  = hs_spv;
    end

    trs_sret_eval #(.XLEN(XLEN)) u_sret (
        .cur     (cur_st),
        .tsr     (st_tsr),
        .vtsr    (hs_vtsr),
        .has_c   (has_c),
        .has_h   (has_h),
        .epc     (sepc),
        .verdict (s_verdict)
    );

    trs_mret_eval #(.XLEN(XLEN), .RULE_W(RULE_W)) u_mret (
        .cur       (cur_st),
        .has_c     (has_c),
        .has_h     (has_h),
        .has_pmp   (has_pmp),
        .pmp_rules (pmp_rules),
        .epc       (mepc),
        .verdict   (m_verdict)
    );

    assign pick = req_is_mret ? m_verdict : s_verdict;

    always_comb begin
        resp_d        = resp_q;
        resp_d.valid  = 1'b0;
        resp_d.commit = 1'b0;
        resp_d.exc    = 1'b0;
        if (req_valid) begin
            resp_d.valid  = 1'b1;
            resp_d.exc    = pick.exc;
            resp_d.commit = !pick.exc;
            resp_d.cause  = pick.cause;
            resp_d.st     = pick.st;
            resp_d.pc     = pick.exc ? '0 : (req_is_mret ? mepc : sepc);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_q         <= '0;
            resp_q.st.priv <= PRIV_M;
        end else begin
            resp_q <= resp_d;
        end
    end

    assign rsp_valid  = resp_q.valid;
    assign rsp_commit = resp_q.commit;
    assign rsp_exc    = resp_q.exc;
    assign rsp_cause  = resp_q.cause;
    assign nxt_priv   = resp_q.st.priv;
    assign nxt_virt   = resp_q.st.virt;
    assign nxt_sie    = resp_q.st.sie;
    assign nxt_spie   = resp_q.st.spie;
    assign nxt_spp    = resp_q.st.spp;
    assign nxt_mie    = resp_q.st.mie;
    assign nxt_mpie   = resp_q.st.mpie;
    assign nxt_mpp    = resp_q.st.mpp;
    assign nxt_mpv    = resp_q.st.mpv;
    assign nxt_spv    = resp_q.st.spv;
    assign ret_pc     = resp_q.pc;

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R2
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R2
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_commit ^ rsp_exc)); // R2
    AST_SRET_USER_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mret && cur_priv == PRIV_U) |=> (rsp_exc && rsp_cause == CAUSE_ILLEGAL)); // R3
    AST_MRET_LOW_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret && cur_priv != PRIV_M) |=> (rsp_exc && rsp_cause == CAUSE_ILLEGAL)); // R9
    AST_SRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_is_mret) |=> (!rsp_commit || (nxt_spie && !nxt_spp))); // R7
    AST_MRET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_is_mret) |=> (!rsp_commit || (nxt_mpie && nxt_mpp == PRIV_U && !nxt_mpv))); // R10
    AST_EXC_ZERO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_exc |-> (ret_pc == '0)); // R14

endmodule

// File: tb/trap_ret_unit_bench.sv
`timescale 1ns/1ps
module trap_ret_unit_bench;

    localparam int XLEN   = 32;
    localparam int RULE_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid, req_is_mret;
    logic [1:0] cur_priv;
    logic cur_virt, st_sie, st_spie, st_spp, st_mie, st_mpie;
    logic [1:0] st_mpp;
    logic st_mpv, st_tsr, hs_spv, hs_vtsr;
    logic [XLEN-1:0] sepc, mepc;
    logic has_c, has_h, has_pmp;
    logic [RULE_W-1:0] pmp_rules;
    logic rsp_valid, rsp_commit, rsp_exc;
    logic [4:0] rsp_cause;
    logic [1:0] nxt_priv;
    logic nxt_virt, nxt_sie, nxt_spie, nxt_spp, nxt_mie, nxt_mpie;
    logic [1:0] nxt_mpp;
    logic nxt_mpv, nxt_spv;
    logic [XLEN-1:0] ret_pc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    trap_ret_unit #(.XLEN(XLEN), .RULE_W(RULE_W)) u_trap_ret_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_mret(req_is_mret),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .st_sie(st_sie), .st_spie(st_spie),
        .st_spp(st_spp), .st_mie(st_mie), .st_mpie(st_mpie), .st_mpp(st_mpp),
        .st_mpv(st_mpv), .st_tsr(st_tsr), .hs_spv(hs_spv), .hs_vtsr(hs_vtsr),
        .sepc(sepc), .mepc(mepc), .has_c(has_c), .has_h(has_h), .has_pmp(has_pmp),
        .pmp_rules(pmp_rules), .rsp_valid(rsp_valid), .rsp_commit(rsp_commit),
        .rsp_exc(rsp_exc), .rsp_cause(rsp_cause), .nxt_priv(nxt_priv),
        .nxt_virt(nxt_virt), .nxt_sie(nxt_sie), .nxt_spie(nxt_spie), .nxt_spp(nxt_spp),
        .nxt_mie(nxt_mie), .nxt_mpie(nxt_mpie), .nxt_mpp(nxt_mpp), .nxt_mpv(nxt_mpv),
        .nxt_spv(nxt_spv), .ret_pc(ret_pc)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic defaults();
        req_valid = 0; req_is_mret = 0; cur_priv = 2'd1; cur_virt = 0;
        st_sie = 0; st_spie = 0; st_spp = 0; st_mie = 0; st_mpie = 0; st_mpp = 2'd0;
        st_mpv = 0; st_tsr = 0; hs_spv = 0; hs_vtsr = 0;
        sepc = 32'h0000_1000; mepc = 32'h0000_2000;
        has_c = 1; has_h = 1; has_pmp = 0; pmp_rules = 5'd4;
    endtask

    task automatic fire(input logic mret);
        req_is_mret = mret;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic expect_exc(input string tag, input logic [4:0] cause);
        chk({tag, " exc"}, {31'd0, rsp_exc}, 32'd1);
        chk({tag, " commit"}, {31'd0, rsp_commit}, 32'd0);
        chk({tag, " cause"}, {27'd0, rsp_cause}, {27'd0, cause});
    endtask

    task automatic t_reset();
        chk("R1 valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 commit", {31'd0, rsp_commit}, 32'd0);
        chk("R1 exc", {31'd0, rsp_exc}, 32'd0);
        chk("R1 priv", {30'd0, nxt_priv}, 32'd3);
    endtask

    task automatic t_latency();
        defaults();
        fire(0);
        chk("R2 valid after req", {31'd0, rsp_valid}, 32'd1);
        chk("R2 one outcome", {31'd0, rsp_commit ^ rsp_exc}, 32'd1);
        @(negedge clk);
        chk("R2 valid drops", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_sret_basic();
        defaults();
        has_h = 0; cur_virt = 1; hs_vtsr = 1; hs_spv = 1;
        st_spie = 1; st_sie = 0; st_spp = 1; sepc = 32'h0000_4444;
        fire(0);
        chk("R7 commit", {31'd0, rsp_commit}, 32'd1);
        chk("R7 sie", {31'd0, nxt_sie}, 32'd1);
        chk("R7 spie", {31'd0, nxt_spie}, 32'd1);
        chk("R7 spp", {31'd0, nxt_spp}, 32'd0);
        chk("R7 priv", {30'd0, nxt_priv}, 32'd1);
        chk("R7 pc", ret_pc, 32'h0000_4444);
        chk("R8 virt kept no hyp", {31'd0, nxt_virt}, 32'd1);
        chk("R8 spv kept no hyp", {31'd0, nxt_spv}, 32'd1);
    endtask

    task automatic t_sret_hyp();
        defaults();
        hs_spv = 1; st_spp = 0; st_spie = 0; st_sie = 1;
        fire(0);
        chk("R8 virt restored", {31'd0, nxt_virt}, 32'd1);
        chk("R8 spv cleared", {31'd0, nxt_spv}, 32'd0);
        chk("R7 priv user", {30'd0, nxt_priv}, 32'd0);
        chk("R7 sie from spie", {31'd0, nxt_sie}, 32'd0);
        defaults();
        cur_virt = 1; hs_spv = 0;
        fire(0);
        chk("R8 virt on kept", {31'd0, nxt_virt}, 32'd1);
        chk("R8 commit virt on", {31'd0, rsp_commit}, 32'd1);
    endtask

    task automatic t_sret_user();
        defaults();
        cur_priv = 2'd0; st_sie = 1; st_spie = 0; st_spp = 1; hs_spv = 1;
        fire(0);
        expect_exc("R3", 5'd2);
        chk("R14 sie held", {31'd0, nxt_sie}, 32'd1);
        chk("R14 spp held", {31'd0, nxt_spp}, 32'd1);
        chk("R14 priv held", {30'd0, nxt_priv}, 32'd0);
        chk("R14 spv held", {31'd0, nxt_spv}, 32'd1);
        chk("R14 pc zero", ret_pc, 32'd0);
    endtask

    task automatic t_misalign();
        defaults();
        has_c = 0; sepc = 32'h0000_1002;
        fire(0);
        expect_exc("R4 no C", 5'd0);
        has_c = 1;
        fire(0);
        chk("R4 with C commits", {31'd0, rsp_commit}, 32'd1);
        chk("R4 pc", ret_pc, 32'h0000_1002);
        defaults();
        cur_priv = 2'd3; has_c = 0; mepc = 32'h0000_2001;
        fire(1);
        expect_exc("R4 mret", 5'd0);
    endtask

    task automatic t_tsr();
        defaults();
        st_tsr = 1;
        fire(0);
        expect_exc("R5 sup", 5'd2);
        cur_priv = 2'd3;
        fire(0);
        chk("R5 machine commits", {31'd0, rsp_commit}, 32'd1);
    endtask

    task automatic t_vtsr();
        defaults();
        cur_virt = 1; hs_vtsr = 1;
        fire(0);
        expect_exc("R6", 5'd22);
    endtask

    task automatic t_priority();
        defaults();
        cur_priv = 2'd0; has_c = 0; sepc = 32'h0000_1002;
        fire(0);
        expect_exc("R13 priv before align", 5'd2);
        defaults();
        has_c = 0; sepc = 32'h0000_1003; st_tsr = 1;
        fire(0);
        expect_exc("R13 align before tsr", 5'd0);
        defaults();
        st_tsr = 1; cur_virt = 1; hs_vtsr = 1;
        fire(0);
        expect_exc("R13 tsr before vtsr", 5'd2);
        defaults();
        cur_priv = 2'd3; has_c = 0; mepc = 32'h0000_2002; has_pmp = 1; pmp_rules = 0; st_mpp = 2'd1;
        fire(1);
        expect_exc("R13 align before rules", 5'd0);
    endtask

    task automatic t_mret_basic();
        defaults();
        cur_priv = 2'd3; st_mie = 1; st_mpie = 0; st_mpp = 2'd1; st_mpv = 1; mepc = 32'h0000_8888;
        fire(1);
        chk("R10 commit", {31'd0, rsp_commit}, 32'd1);
        chk("R10 mie", {31'd0, nxt_mie}, 32'd0);
        chk("R10 mpie", {31'd0, nxt_mpie}, 32'd1);
        chk("R10 mpp", {30'd0, nxt_mpp}, 32'd0);
        chk("R10 mpv", {31'd0, nxt_mpv}, 32'd0);
        chk("R10 priv", {30'd0, nxt_priv}, 32'd1);
        chk("R10 pc", ret_pc, 32'h0000_8888);
        chk("R11 virt from mpv", {31'd0, nxt_virt}, 32'd1);
        defaults();
        cur_priv = 2'd3; has_h = 0; st_mpv = 1; cur_virt = 0; st_mpp = 2'd3;
        fire(1);
        chk("R11 no hyp virt kept", {31'd0, nxt_virt}, 32'd0);
        chk("R10 mpv cleared", {31'd0, nxt_mpv}, 32'd0);
        chk("R10 priv machine", {30'd0, nxt_priv}, 32'd3);
    endtask

    task automatic t_mret_low();
        defaults();
        cur_priv = 2'd1;
        fire(1);
        expect_exc("R9 sup", 5'd2);
        cur_priv = 2'd0;
        fire(1);
        expect_exc("R9 user", 5'd2);
    endtask

    task automatic t_pmp();
        defaults();
        cur_priv = 2'd3; has_pmp = 1; pmp_rules = 0; st_mpp = 2'd1;
        fire(1);
        expect_exc("R12 no rules", 5'd2);
        st_mpp = 2'd3;
        fire(1);
        chk("R12 mpp machine", {31'd0, rsp_commit}, 32'd1);
        st_mpp = 2'd1; pmp_rules = 5'd2;
        fire(1);
        chk("R12 rules present", {31'd0, rsp_commit}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        defaults();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_sret_basic();
        t_sret_hyp();
        t_sret_user();
        t_misalign();
        t_tsr();
        t_vtsr();
        t_priority();
        t_mret_basic();
        t_mret_low();
        t_pmp();
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule